// File: doc/BRIEF.md
# Toroidal Multi-Hop Lane Shift Network

This block holds a square grid of lane registers and, on a single strobe, rotates the whole grid by one to four positions along one axis. Every lane moves by the same amount in the same direction, so each shift is a permutation of the entire grid. A value that is pushed past an edge comes back in at the opposite edge of its own row or column, which makes the grid a torus. Stencil kernels such as convolution and local filters use it to bring neighbouring samples into each lane.

The grid can also be written in one cycle through a wide parallel load port. A load beats a shift that arrives in the same cycle. With neither strobe asserted, the grid keeps its contents. All results are registered and are visible one clock after the strobe.

Top module: `torus_shift_grid`

## Requirements
- R1: While reset is asserted and after it is released, every lane reads zero until the first load.
- R2: With `load_en` high, all lanes take the `load_data` values at the next clock edge. Lane (r,c) occupies bits [(r*16+c)*16 +: 16] of both `load_data` and `grid_q`.
- R3: When `load_en` and `shift_en` are high in the same cycle, the load wins and the grid takes `load_data` exactly.
- R4: With `load_en` and `shift_en` both low, every lane keeps its value.
- R5: With `shift_dir` = 2'b10 (east), lane (r,c) takes the old value of lane (r,(c-k) mod 16), where k = `hop_code` + 1.
- R6: With `shift_dir` = 2'b11 (west), lane (r,c) takes the old value of lane (r,(c+k) mod 16).
- R7: With `shift_dir` = 2'b00 (north), lane (r,c) takes the old value of lane ((r+k) mod 16,c).
- R8: With `shift_dir` = 2'b01 (south), lane (r,c) takes the old value of lane ((r-k) mod 16,c).
- R9: `hop_code` values 0, 1, 2 and 3 select shifts of 1, 2, 3 and 4 positions. A four-hop east shift followed by a four-hop west shift restores the grid exactly.
- R10: The result of a load or a shift appears at `grid_q` one clock edge after the strobe, and the strobe has no effect before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Parallel load strobe |
| load_data | input | 4096 | Values for all 256 lanes |
| shift_en | input | 1 | Shift strobe |
| shift_dir | input | 2 | 00 north, 01 south, 10 east, 11 west |
| hop_code | input | 2 | Hop count minus one |
| grid_q | output | 4096 | Current value of all 256 lanes |

## Verification
Loads, shifts and holds all take effect at the first rising edge after the strobe, so each result is due exactly one cycle later. The bench drives strobes on the falling edge, removes them at the next falling edge, and compares `grid_q` there against a modulo-index reference grid that it updates at the same moment. The reset value is read while reset is still low and again after release. Wrap-around lanes are also checked against values computed directly from the load pattern, so the check does not depend only on the reference grid.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
   typedef enum logic [1:0] {
      DIR_NORTH = 2'b00,
      DIR_SOUTH = 2'b01,
      DIR_EAST  = 2'b10,
      DIR_WEST  = 2'b11
   } shift_dir_e;

   // a move toward higher index means lane i takes lane i-k
   function automatic logic dir_toward_high(input shift_dir_e d);
      return (d == DIR_SOUTH) || (d == DIR_EAST);
   endfunction

   function automatic logic dir_horizontal(input shift_dir_e d);
      return (d == DIR_EAST) || (d == DIR_WEST);
   endfunction
endpackage

// File: rtl/tsg_dir_decode.sv
module tsg_dir_decode
   import tsg_pkg::*;
(
   input  logic [1:0] shift_dir,
   output logic       horiz,
   output logic       toward_high
);
   shift_dir_e dir_e;

   always_comb begin
      dir_e       = shift_dir_e'(shift_dir);
      horiz       = dir_horizontal(dir_e);
      toward_high = dir_toward_high(dir_e);
   end
endmodule

// File: rtl/tsg_ring_rotate.sv
module tsg_ring_rotate #(
   parameter int N     = 16,
   parameter int W     = 16,
   parameter int HOP_W = 2
) (
   input  logic [N*W-1:0]   vec_in,
   input  logic [HOP_W-1:0] hop_code,
   input  logic             toward_high,
   output logic [N*W-1:0]   vec_out
);
   localparam int NCAND = 2 ** HOP_W;

   logic [N*W-1:0] up_c [NCAND];
   logic [N*W-1:0] dn_c [NCAND];

   // candidate j rotates the ring by j+1 positions
   for (genvar j = 0; j < NCAND; j++) begin : g_amt
      localparam int K = (j + 1) % N;
      for (genvar i = 0; i < N; i++) begin : g_lane
         localparam int SRC_UP = (i + N - K) % N;
         localparam int SRC_DN = (i + K) % N;
         assign up_c[j][i*W +: W] = vec_in[SRC_UP*W +: W];
         assign dn_c[j][i*W +: W] = vec_in[SRC_DN*W +: W];
      end
   end

   assign vec_out = toward_high ? up_c[hop_code] : dn_c[hop_code];
endmodule

// File: rtl/tsg_grid_reg.sv
module tsg_grid_reg #(
   parameter int BITS = 4096
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_en,
   input  logic [BITS-1:0] load_data,
   input  logic            shift_en,
   input  logic [BITS-1:0] shift_data,
   output logic [BITS-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load_en) begin
         q <= load_data;
      end else if (shift_en) begin
         q <= shift_data;
      end
   end
endmodule

// File: rtl/torus_shift_grid.sv
module torus_shift_grid #(
   parameter int ROWS    = 16,
   parameter int COLS    = 16,
   parameter int LANE_W  = 16,
   parameter int MAX_HOP = 4,
   parameter int HOP_W   = $clog2(MAX_HOP)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_en,
   input  logic [ROWS*COLS*LANE_W-1:0]   load_data,
   input  logic                          shift_en,
   input  logic [1:0]                    shift_dir,
   input  logic [HOP_W-1:0]              hop_code,
   output logic [ROWS*COLS*LANE_W-1:0]   grid_q
);
   localparam int LANES   = ROWS * COLS;
   localparam int BITS    = LANES * LANE_W;
   localparam int ROW_BITS = COLS * LANE_W;
   localparam int COL_BITS = ROWS * LANE_W;

   if (MAX_HOP != 2 ** HOP_W) begin : g_bad_hop
      $error("MAX_HOP must be a power of two matching HOP_W");
   end
   if (MAX_HOP >= ROWS || MAX_HOP >= COLS) begin : g_bad_dim
      $error("MAX_HOP must be smaller than both grid dimensions");
   end
   if (LANE_W < 1) begin : g_bad_w
      $error("LANE_W must be positive");
   end

   logic            horiz;
   logic            toward_high;
   logic [BITS-1:0] horiz_next;
   logic [BITS-1:0] vert_next;
   logic [BITS-1:0] shift_next;

   tsg_dir_decode u_dec (
      .shift_dir   (shift_dir),
      .horiz       (horiz),
      .toward_high (toward_high)
   );

   // rows: contiguous slices of the grid, rotated along the column index
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      tsg_ring_rotate #(.N(COLS), .W(LANE_W), .HOP_W(HOP_W)) u_rot (
         .vec_in      (grid_q[r*ROW_BITS +: ROW_BITS]),
         .hop_code    (hop_code),
         .toward_high (toward_high),
         .vec_out     (horiz_next[r*ROW_BITS +: ROW_BITS])
      );
   end

   // columns: gathered across rows, rotated along the row index
   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [COL_BITS-1:0] col_in;
      logic [COL_BITS-1:0] col_out;
      for (genvar r = 0; r < ROWS; r++) begin : g_gather
         assign col_in[r*LANE_W +: LANE_W] = grid_q[(r*COLS+c)*LANE_W +: LANE_W];
         assign vert_next[(r*COLS+c)*LANE_W +: LANE_W] = col_out[r*LANE_W +: LANE_W];
      end
      tsg_ring_rotate #(.N(ROWS), .W(LANE_W), .HOP_W(HOP_W)) u_rot (
         .vec_in      (col_in),
         .hop_code    (hop_code),
         .toward_high (toward_high),
         .vec_out     (col_out)
      );
   end

   assign shift_next = horiz ? horiz_next : vert_next;

   tsg_grid_reg #(.BITS(BITS)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (load_en),
      .load_data  (load_data),
      .shift_en   (shift_en),
      .shift_data (shift_next),
      .q          (grid_q)
   );
endmodule

// File: rtl/tsg_check.sv
module tsg_check #(
   parameter int ROWS    = 16,
   parameter int COLS    = 16,
   parameter int LANE_W  = 16,
   parameter int MAX_HOP = 4,
   parameter int HOP_W   = $clog2(MAX_HOP)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        load_en,
   input logic [ROWS*COLS*LANE_W-1:0] load_data,
   input logic                        shift_en,
   input logic [1:0]                  shift_dir,
   input logic [HOP_W-1:0]            hop_code,
   input logic [ROWS*COLS*LANE_W-1:0] grid_q
);
   logic [LANE_W-1:0] prev_corner;
   int                prev_k;

   always_ff @(posedge clk) begin
      prev_corner <= grid_q[LANE_W-1:0];
      prev_k      <= int'(hop_code) + 1;
   end

   // R1
   reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (grid_q == '0));

   // R2
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !shift_en) |=> (grid_q == $past(load_data)));

   // R3
   load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && shift_en) |=> (grid_q == $past(load_data)));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !shift_en) |=> $stable(grid_q));

   // R5
   east_corner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !load_en && shift_dir == 2'b10) |=>
      (grid_q[prev_k*LANE_W +: LANE_W] == prev_corner));

   // R7
   north_corner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !load_en && shift_dir == 2'b00) |=>
      (grid_q[(ROWS-prev_k)*COLS*LANE_W +: LANE_W] == prev_corner));
endmodule

bind torus_shift_grid tsg_check #(
   .ROWS(ROWS), .COLS(COLS), .LANE_W(LANE_W), .MAX_HOP(MAX_HOP), .HOP_W(HOP_W)
) u_chk (.*);

// File: tb/sim_torus_shift_grid.sv
module sim_torus_shift_grid;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 16;
   localparam int W  = 16;
   localparam int NB = N * N * W;

   // each entry: {dir[1:0], hop_code[1:0]}
   localparam logic [3:0] OPS [12] = '{
      4'b10_00, 4'b10_11, 4'b11_01, 4'b00_00, 4'b01_10, 4'b00_11,
      4'b11_10, 4'b01_01, 4'b10_01, 4'b01_11, 4'b11_00, 4'b00_10
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_en = 1'b0;
   logic [NB-1:0] load_data = '0;
   logic          shift_en = 1'b0;
   logic [1:0]    shift_dir = 2'b00;
   logic [1:0]    hop_code = 2'b00;
   logic [NB-1:0] grid_q;

   logic [W-1:0]  mdl [N][N];
   logic [NB-1:0] orig;
   int            n_chk = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   torus_shift_grid u0 (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
      .shift_en(shift_en), .shift_dir(shift_dir), .hop_code(hop_code),
      .grid_q(grid_q)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [W-1:0] pat(input int r, input int c, input int s);
      logic [7:0] idx;
      idx = 8'((r * N + c + s) & 8'hFF);
      return {idx, ~idx ^ 8'(s)};
   endfunction

   function automatic logic [NB-1:0] pack_mdl();
      logic [NB-1:0] v;
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            v[(r*N+c)*W +: W] = mdl[r][c];
      return v;
   endfunction

   task automatic mdl_load(input logic [NB-1:0] v);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            mdl[r][c] = v[(r*N+c)*W +: W];
   endtask

   task automatic mdl_shift(input logic [1:0] d, input logic [1:0] h);
      logic [W-1:0] t [N][N];
      int k;
      k = int'(h) + 1;
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            case (d)
               2'b00: t[r][c] = mdl[(r + k) % N][c];
               2'b01: t[r][c] = mdl[(r + N - k) % N][c];
               2'b10: t[r][c] = mdl[r][(c + N - k) % N];
               default: t[r][c] = mdl[r][(c + k) % N];
            endcase
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            mdl[r][c] = t[r][c];
   endtask

   task automatic check_grid(input string req, input logic [NB-1:0] exp_v);
      n_chk++;
      if (grid_q !== exp_v) begin
         n_fail++;
         for (int i = 0; i < N * N; i++)
            if (grid_q[i*W +: W] !== exp_v[i*W +: W]) begin
               $display("FAIL %s lane %0d: got %h expected %h", req, i,
                        grid_q[i*W +: W], exp_v[i*W +: W]);
               break;
            end
      end
   endtask

   task automatic check_lane(input string req, input int r, input int c,
                             input logic [W-1:0] exp_v);
      n_chk++;
      if (grid_q[(r*N+c)*W +: W] !== exp_v) begin
         n_fail++;
         $display("FAIL %s lane (%0d,%0d): got %h expected %h", req, r, c,
                  grid_q[(r*N+c)*W +: W], exp_v);
      end
   endtask

   task automatic do_load(input logic [NB-1:0] v);
      @(negedge clk);
      load_en = 1'b1;
      load_data = v;
      @(negedge clk);
      load_en = 1'b0;
      mdl_load(v);
   endtask

   task automatic do_shift(input logic [1:0] d, input logic [1:0] h);
      @(negedge clk);
      shift_en = 1'b1;
      shift_dir = d;
      hop_code = h;
      @(negedge clk);
      shift_en = 1'b0;
      mdl_shift(d, h);
   endtask

   function automatic string req_of(input logic [1:0] d);
      case (d)
         2'b00: return "R7 north";
         2'b01: return "R8 south";
         2'b10: return "R5 east";
         default: return "R6 west";
      endcase
   endfunction

   initial begin
      logic [NB-1:0] p0;
      logic [NB-1:0] p1;
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            p0[(r*N+c)*W +: W] = pat(r, c, 0);
            p1[(r*N+c)*W +: W] = pat(r, c, 77);
         end

      // R1: zero during reset and after release
      repeat (2) @(negedge clk);
      check_grid("R1 in reset", '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_grid("R1 after release", '0);

      // R2, R10: load visible one edge later, not before
      @(negedge clk);
      load_en = 1'b1;
      load_data = p0;
      #1;
      check_grid("R10 no effect before edge", '0);
      @(negedge clk);
      load_en = 1'b0;
      mdl_load(p0);
      check_grid("R2 load", p0);

      // table walk: R5 R6 R7 R8 R9 against the modulo-index model
      foreach (OPS[i]) begin
         do_shift(OPS[i][3:2], OPS[i][1:0]);
         check_grid($sformatf("%s hop %0d R9", req_of(OPS[i][3:2]),
                    int'(OPS[i][1:0]) + 1), pack_mdl());
      end

      // R4: hold for several cycles
      p1 = pack_mdl();
      repeat (3) @(negedge clk);
      check_grid("R4 hold", p1);

      // R5 wrap corner, computed from the pattern directly
      do_load(p0);
      do_shift(2'b10, 2'b00);
      check_lane("R5 east wrap", 3, 0, pat(3, 15, 0));
      check_lane("R5 east inner", 3, 9, pat(3, 8, 0));

      // R7 wrap corner
      do_load(p0);
      do_shift(2'b00, 2'b00);
      check_lane("R7 north wrap", 15, 7, pat(0, 7, 0));

      // R8 wrap corner at four hops
      do_load(p0);
      do_shift(2'b01, 2'b11);
      check_lane("R8 south wrap", 2, 5, pat(14, 5, 0));

      // R6 wrap corner at three hops
      do_load(p0);
      do_shift(2'b11, 2'b10);
      check_lane("R6 west wrap", 6, 14, pat(6, 1, 0));

      // R9: east 4 then west 4 restores
      do_load(p0);
      do_shift(2'b10, 2'b11);
      check_grid("R9 east four", pack_mdl());
      do_shift(2'b11, 2'b11);
      check_grid("R9 restore", p0);

      // R3: load wins over a simultaneous shift
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            p1[(r*N+c)*W +: W] = pat(r, c, 33);
      @(negedge clk);
      load_en = 1'b1;
      load_data = p1;
      shift_en = 1'b1;
      shift_dir = 2'b10;
      hop_code = 2'b01;
      @(negedge clk);
      load_en = 1'b0;
      shift_en = 1'b0;
      check_grid("R3 load priority", p1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule